// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a byte-wide parallel NOR flash bus. It samples the active-low chip enable, write enable and output enable together with the address and data buses on its own clock. Write strobes become a stream of (address, data) events, and a command decoder checks each event against a fixed key sequence. A recognised byte program or chip erase hands control to an embedded engine. The engine then works on a small register-based memory array with no further help from the host.

While the engine is busy, any read returns a status byte in place of array data. The host polls bit 7 of that byte until it shows the final value. For a program that value is bit 7 of the written byte. For an erase it is 1. While the engine is busy, the decoder takes no command writes. Programming can only clear bits, so a location can return to 1 only through a chip erase. Chip erase writes zero to every location first and then writes 0xFF to every location. Its busy time therefore grows with the array depth.

Command decoder states: `CMD_READ` (idle), `CMD_UNL1` (first key seen), `CMD_UNL2` (second key seen), `CMD_PGM_DATA` (waiting for the target write), `CMD_ERS_SETUP` (erase setup seen), `CMD_ERS_UNL1` and `CMD_ERS_UNL2` (second key pair of the erase).

Decoder transitions:
- READ→UNL1 on 0xAA@0x555.
- UNL1→UNL2 on 0x55@0x2AA.
- UNL2→PGM_DATA on 0xA0@0x555.
- UNL2→ERS_SETUP on 0x80@0x555.
- ERS_SETUP→ERS_UNL1 on 0xAA@0x555.
- ERS_UNL1→ERS_UNL2 on 0x55@0x2AA.
- PGM_DATA→READ on any write, which starts a program.
- ERS_UNL2→READ on any write. A write of 0x10@0x555 also starts a chip erase.
- Any other write, or a write of 0xF0 outside PGM_DATA, goes to READ.
- The decoder is held in READ while the engine is busy.

Engine states: `ENG_IDLE`, `ENG_PROG`, `ENG_PREPGM` (zero fill), `ENG_WIPE` (fill with 0xFF). Engine transitions:
- IDLE→PROG on a program start.
- IDLE→PREPGM on an erase start.
- PROG→IDLE after PROG_CYCLES cycles.
- PREPGM→WIPE after the last location has been zero-filled.
- WIPE→IDLE after the last location has been filled with 0xFF.

Top module: `flash_seq_ctrl`

## Requirements
- R1: After reset every array location holds 0xFF, the decoder is in read mode, and `dout` is 0x00 whenever `ce_n` or `oe_n` is high.
- R2: In read mode, with `ce_n` and `oe_n` low and the engine idle, `dout` shows the byte stored at `addr[IW-1:0]` in the same cycle.
- R3: A byte program is the four writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then data@target. Only address bits [10:0] take part in key matching.
- R4: A program stores the old byte AND the new data, so it never turns a 0 bit into a 1.
- R5: A program keeps the engine busy for exactly PROG_CYCLES clock cycles, starting at the second rising clock edge after the final strobe ends. During that time reads return {~data[7], 7'b0}.
- R6: Writes arriving while the engine is busy are ignored. The decoder is in read mode when the operation ends.
- R7: A chip erase is the six writes 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, 0x10@0x555. It keeps the engine busy for 2·DEPTH·ERASE_STEP cycles, with the same start rule as R5. Reads return 0x00 while it runs, and afterwards every location reads 0xFF.
- R8: A write that does not match the expected next step of a sequence returns the decoder to read mode. No later data write is programmed unless a full sequence precedes it.
- R9: A write of 0xF0 in any decoder state except the program-data state returns the decoder to read mode.
- R10: The write address is taken on the first clock at which `ce_n` and `we_n` are both low. The write data is taken on the last such clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| dout | output | 8 | Read data or status byte; 0x00 when not selected for read |

## Verification
A write strobe that ends with the pins released before rising edge E is turned into a decoder event at E. The decoder and the engine act on that event at E+1. A bench read that is driven just after E therefore still sees the old array byte. Reads driven after E+1 up to E+PROG_CYCLES (or E+2·DEPTH·ERASE_STEP for an erase) see the status byte, and the next read sees the result. The bench issues one read per cycle right after the final write and queues an exact expected byte for each cycle: old value, then status for the full busy window, then the new value. So the busy length is checked to the cycle and not by open-ended polling. Reads are driven just after a rising edge and compared at the following falling edge, because `dout` is combinational from the bus pins and the array.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        CMD_READ,
        CMD_UNL1,
        CMD_UNL2,
        CMD_PGM_DATA,
        CMD_ERS_SETUP,
        CMD_ERS_UNL1,
        CMD_ERS_UNL2
    } cmd_state_t;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_PROG,
        ENG_PREPGM,
        ENG_WIPE
    } eng_state_t;

    // Key addresses, compared on the low eleven address bits
    localparam int unsigned KEY_AW = 11;
    localparam logic [KEY_AW-1:0] KEY_ADDR_HI = 11'h555;
    localparam logic [KEY_AW-1:0] KEY_ADDR_LO = 11'h2AA;

    // Command bytes
    localparam logic [7:0] KEY_BYTE_1 = 8'hAA;
    localparam logic [7:0] KEY_BYTE_2 = 8'h55;
    localparam logic [7:0] OP_PROGRAM = 8'hA0;
    localparam logic [7:0] OP_ERASE   = 8'h80;
    localparam logic [7:0] OP_CHIP    = 8'h10;
    localparam logic [7:0] OP_ABORT   = 8'hF0;

endpackage

// File: rtl/flash_bus_capture.sv
// Turns ce_n/we_n strobes into single-cycle write events.
module flash_bus_capture #(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic          wr_evt,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data
);

    logic strobe;
    logic strobe_q;

    assign strobe = !ce_n && !we_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            wr_evt   <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            strobe_q <= strobe;
            // Event fires once the strobe has ended
            wr_evt   <= strobe_q && !strobe;
            // Address: first clock of the strobe (later falling enable)
            if (strobe && !strobe_q) begin
                wr_addr <= addr;
            end
            // Data: keeps following until the strobe ends (first rising enable)
            if (strobe) begin
                wr_data <= din;
            end
        end
    end

endmodule

// File: rtl/flash_cmd_fsm.sv
// Decodes the key/command write sequences.
module flash_cmd_fsm
    import flash_seq_pkg::*;
#(
    parameter int unsigned AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_evt,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          eng_busy,
    output logic          start_prog,
    output logic          start_erase,
    output cmd_state_t    cmd_state
);

    cmd_state_t nxt;
    logic hit_key1;
    logic hit_key2;
    logic hit_prog;
    logic hit_erase;
    logic hit_chip;
    logic hit_abort;
    logic take;

    assign take      = wr_evt && !eng_busy;
    assign hit_key1  = (wr_data == KEY_BYTE_1) && (wr_addr[KEY_AW-1:0] == KEY_ADDR_HI);
    assign hit_key2  = (wr_data == KEY_BYTE_2) && (wr_addr[KEY_AW-1:0] == KEY_ADDR_LO);
    assign hit_prog  = (wr_data == OP_PROGRAM) && (wr_addr[KEY_AW-1:0] == KEY_ADDR_HI);
    assign hit_erase = (wr_data == OP_ERASE)   && (wr_addr[KEY_AW-1:0] == KEY_ADDR_HI);
    assign hit_chip  = (wr_data == OP_CHIP)    && (wr_addr[KEY_AW-1:0] == KEY_ADDR_HI);
    assign hit_abort = (wr_data == OP_ABORT);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_state <= CMD_READ;
        end else begin
            cmd_state <= nxt;
        end
    end

    // Next state
    always_comb begin
        nxt = cmd_state;
        if (eng_busy) begin
            nxt = CMD_READ;
        end else if (wr_evt) begin
            if (hit_abort && cmd_state != CMD_PGM_DATA) begin
                nxt = CMD_READ;
            end else begin
                unique case (cmd_state)
                    CMD_READ:      nxt = hit_key1  ? CMD_UNL1      : CMD_READ;
                    CMD_UNL1:      nxt = hit_key2  ? CMD_UNL2      : CMD_READ;
                    CMD_UNL2:      nxt = hit_prog  ? CMD_PGM_DATA  :
                                         hit_erase ? CMD_ERS_SETUP : CMD_READ;
                    CMD_PGM_DATA:  nxt = CMD_READ;
                    CMD_ERS_SETUP: nxt = hit_key1  ? CMD_ERS_UNL1  : CMD_READ;
                    CMD_ERS_UNL1:  nxt = hit_key2  ? CMD_ERS_UNL2  : CMD_READ;
                    CMD_ERS_UNL2:  nxt = CMD_READ;
                    default:       nxt = CMD_READ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        start_prog  = take && (cmd_state == CMD_PGM_DATA);
        start_erase = take && (cmd_state == CMD_ERS_UNL2) && hit_chip;
    end

endmodule

// File: rtl/flash_embed_engine.sv
// Runs the self-timed program and chip-erase operations.
module flash_embed_engine
    import flash_seq_pkg::*;
#(
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned PROG_CYCLES = 8,
    parameter int unsigned ERASE_STEP  = 2,
    localparam int unsigned IW = $clog2(DEPTH),
    localparam int unsigned CMAX = (PROG_CYCLES > ERASE_STEP) ? PROG_CYCLES : ERASE_STEP,
    localparam int unsigned CW = $clog2(CMAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_prog,
    input  logic          start_erase,
    input  logic [IW-1:0] prog_idx,
    input  logic [7:0]    prog_data,
    input  logic [7:0]    old_byte,
    output logic          busy,
    output logic          erasing,
    output logic          tgt_bit7,
    output logic [IW-1:0] cur_idx,
    output logic          mem_we,
    output logic [7:0]    mem_wdata
);

    eng_state_t    st;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [7:0]    pdata;
    logic          prog_last;
    logic          step_last;
    logic          idx_last;

    assign prog_last = (cnt == CW'(PROG_CYCLES - 1));
    assign step_last = (cnt == CW'(ERASE_STEP - 1));
    assign idx_last  = (idx == IW'(DEPTH - 1));

    // State register with sequencing counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= ENG_IDLE;
            cnt   <= '0;
            idx   <= '0;
            pdata <= 8'hFF;
        end else begin
            unique case (st)
                ENG_IDLE: begin
                    cnt <= '0;
                    if (start_prog) begin
                        st    <= ENG_PROG;
                        idx   <= prog_idx;
                        pdata <= prog_data;
                    end else if (start_erase) begin
                        st  <= ENG_PREPGM;
                        idx <= '0;
                    end
                end
                ENG_PROG: begin
                    if (prog_last) begin
                        st  <= ENG_IDLE;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ENG_PREPGM: begin
                    if (step_last) begin
                        cnt <= '0;
                        if (idx_last) begin
                            idx <= '0;
                            st  <= ENG_WIPE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ENG_WIPE: begin
                    if (step_last) begin
                        cnt <= '0;
                        if (idx_last) begin
                            idx <= '0;
                            st  <= ENG_IDLE;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: st <= ENG_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy      = (st != ENG_IDLE);
        erasing   = (st == ENG_PREPGM) || (st == ENG_WIPE);
        tgt_bit7  = pdata[7];
        cur_idx   = idx;
        mem_we    = 1'b0;
        mem_wdata = 8'hFF;
        unique case (st)
            ENG_IDLE: begin
                mem_we = 1'b0;
            end
            ENG_PROG: begin
                mem_we    = prog_last;
                mem_wdata = old_byte & pdata;
            end
            ENG_PREPGM: begin
                mem_we    = step_last;
                mem_wdata = 8'h00;
            end
            ENG_WIPE: begin
                mem_we    = step_last;
                mem_wdata = 8'hFF;
            end
            default: mem_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/flash_array.sv
// Register-based byte array with one write and two read ports.
module flash_array #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned IW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ridx_a,
    output logic [7:0]    rdata_a,
    input  logic [IW-1:0] ridx_b,
    output logic [7:0]    rdata_b
);

    logic [7:0] cells [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cells[g] <= 8'hFF;
            end else if (we && widx == IW'(g)) begin
                cells[g] <= wdata;
            end
        end
    end

    assign rdata_a = cells[ridx_a];
    assign rdata_b = cells[ridx_b];

endmodule

// File: rtl/flash_seq_ctrl.sv
module flash_seq_ctrl
    import flash_seq_pkg::*;
#(
    parameter int unsigned AW          = 11,
    parameter int unsigned DEPTH       = 16,
    parameter int unsigned PROG_CYCLES = 8,
    parameter int unsigned ERASE_STEP  = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    output logic [7:0]    dout
);

    localparam int unsigned IW = $clog2(DEPTH);

    logic          wr_evt;
    logic [AW-1:0] wr_addr;
    logic [7:0]    wr_data;
    logic          start_prog;
    logic          start_erase;
    cmd_state_t    cmd_state;
    logic          eng_busy;
    logic          eng_erasing;
    logic          tgt_bit7;
    logic [IW-1:0] eng_idx;
    logic          mem_we;
    logic [7:0]    mem_wdata;
    logic [7:0]    rd_byte;
    logic [7:0]    old_byte;

    flash_bus_capture #(.AW(AW)) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .addr    (addr),
        .din     (din),
        .wr_evt  (wr_evt),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    flash_cmd_fsm #(.AW(AW)) i_cmd (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_evt      (wr_evt),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .eng_busy    (eng_busy),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .cmd_state   (cmd_state)
    );

    flash_embed_engine #(
        .DEPTH       (DEPTH),
        .PROG_CYCLES (PROG_CYCLES),
        .ERASE_STEP  (ERASE_STEP)
    ) i_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_prog  (start_prog),
        .start_erase (start_erase),
        .prog_idx    (wr_addr[IW-1:0]),
        .prog_data   (wr_data),
        .old_byte    (old_byte),
        .busy        (eng_busy),
        .erasing     (eng_erasing),
        .tgt_bit7    (tgt_bit7),
        .cur_idx     (eng_idx),
        .mem_we      (mem_we),
        .mem_wdata   (mem_wdata)
    );

    flash_array #(.DEPTH(DEPTH)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .widx    (eng_idx),
        .wdata   (mem_wdata),
        .ridx_a  (addr[IW-1:0]),
        .rdata_a (rd_byte),
        .ridx_b  (eng_idx),
        .rdata_b (old_byte)
    );

    // Read path: status while busy, array byte otherwise
    always_comb begin
        if (ce_n || oe_n) begin
            dout = 8'h00;
        end else if (eng_busy) begin
            dout = eng_erasing ? 8'h00 : {~tgt_bit7, 7'b0};
        end else begin
            dout = rd_byte;
        end
    end

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker
    import flash_seq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       ce_n,
    input logic       oe_n,
    input logic [7:0] dout,
    input cmd_state_t cmd_state,
    input logic       start_prog,
    input logic       start_erase,
    input logic       eng_busy,
    input logic       eng_erasing,
    input logic       mem_we,
    input logic [7:0] mem_wdata,
    input logic [7:0] old_byte
);

    p_one_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_prog, start_erase}));

    p_clear_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !eng_erasing) |-> ((mem_wdata & ~old_byte) == 8'h00));

    p_prog_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        start_prog |=> (eng_busy && !eng_erasing));

    p_no_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> (!start_prog && !start_erase));

    p_parked_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> (cmd_state == CMD_READ));

    p_erase_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_erase |=> (eng_busy && eng_erasing));

    p_erase_status_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_erasing && !ce_n && !oe_n) |-> (dout[7] == 1'b0));

endmodule

bind flash_seq_ctrl flash_seq_checker i_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .ce_n        (ce_n),
    .oe_n        (oe_n),
    .dout        (dout),
    .cmd_state   (cmd_state),
    .start_prog  (start_prog),
    .start_erase (start_erase),
    .eng_busy    (eng_busy),
    .eng_erasing (eng_erasing),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata),
    .old_byte    (old_byte)
);

// File: tb/test_flash_seq_ctrl.sv
module test_flash_seq_ctrl;

    localparam int AW = 11;
    localparam int DEPTH = 16;
    localparam int PC = 8;
    localparam int EB = 2 * DEPTH * 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          we_n = 1'b1;
    logic          oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic [7:0]    dout;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sb[$];
    logic  rd_strobe = 1'b0;
    int    n_vec = 0;
    int    n_bad = 0;
    logic [7:0] model [DEPTH];

    always #5 clk = ~clk;

    flash_seq_ctrl i_flash_seq_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (ce_n),
        .we_n  (we_n),
        .oe_n  (oe_n),
        .addr  (addr),
        .din   (din),
        .dout  (dout)
    );

    // Monitor: compare each scheduled read at the falling edge
    always @(negedge clk) begin
        if (rd_strobe) begin
            item_t it;
            it = sb.pop_front();
            n_vec++;
            if (dout !== it.exp) begin
                n_bad++;
                $display("FAIL %s: dout=%h expected %h", it.tag, dout, it.exp);
            end
        end
    end

    task automatic vcheck(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: schedule one read and its expected byte
    task automatic rd_expect(input logic [AW-1:0] a, input logic [7:0] exp, input string tag);
        item_t it;
        @(posedge clk); #1;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        it.exp = exp; it.tag = tag;
        sb.push_back(it);
        rd_strobe = 1'b1;
        @(negedge clk); #1;
        rd_strobe = 1'b0; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic peek(input logic [AW-1:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
        @(negedge clk);
        v = dout;
        #1; ce_n = 1'b1; oe_n = 1'b1;
    endtask

    // Write with optional mid-strobe change of address and data
    task automatic wr2(input logic [AW-1:0] a1, input logic [7:0] d1,
                       input logic [AW-1:0] a2, input logic [7:0] d2);
        @(posedge clk); #1;
        addr = a1; din = d1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        @(posedge clk); #1;
        addr = a2; din = d2;
        @(posedge clk); #1;
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
        wr2(a, d, a, d);
    endtask

    task automatic prog_seq(input logic [AW-1:0] a, input logic [7:0] d);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'hA0);
        wr(a, d);
    endtask

    task automatic erase_seq();
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'h80);
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'h10);
    endtask

    // Per-cycle reads right after a program sequence
    task automatic prog_timed(input int idx, input logic [7:0] d, input string tag);
        logic [7:0] old;
        logic [7:0] nw;
        old = model[idx];
        nw  = old & d;
        prog_seq(AW'(idx), d);
        for (int i = 1; i <= PC + 3; i++) begin
            if (i == 1) rd_expect(AW'(idx), old, tag);
            else if (i <= PC + 1) rd_expect(AW'(idx), {~d[7], 7'b0}, tag);
            else rd_expect(AW'(idx), nw, tag);
        end
        model[idx] = nw;
    endtask

    task automatic wait_idle(input logic [AW-1:0] a, input logic [7:0] want);
        logic [7:0] v;
        for (int i = 0; i < 400; i++) begin
            peek(a, v);
            if (v == want) break;
        end
    endtask

    initial begin
        logic [7:0] v;
        for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset contents and idle bus value
        @(negedge clk);
        vcheck(dout, 8'h00, "R1 idle bus");
        for (int i = 0; i < DEPTH; i += 5) rd_expect(AW'(i), 8'hFF, "R1 reset content");

        // R3 R5: program with exact busy window
        prog_timed(5, 8'h3C, "R5 R3 program 0x3C");
        // R4: bits only clear; 0xF0 as program data is data
        prog_timed(5, 8'hF0, "R4 AND 0xF0");
        prog_timed(2, 8'hA5, "R3 program 0xA5");
        // R2: read mode across locations
        rd_expect(11'h002, 8'hA5, "R2 read loc2");
        rd_expect(11'h7F5, 8'h30, "R2 read aliases low bits");
        rd_expect(11'h003, 8'hFF, "R2 read loc3");

        // R8: broken unlock then data write not programmed
        wr(11'h555, 8'hAA);
        wr(11'h123, 8'h55);
        wr(11'h555, 8'hA0);
        wr(11'h007, 8'h00);
        repeat (PC + 3) @(posedge clk);
        rd_expect(11'h007, 8'hFF, "R8 broken sequence ignored");
        prog_timed(7, 8'h0F, "R8 recovery program");

        // R9: abort after two keys, and after erase setup
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h100, 8'hF0);
        wr(11'h008, 8'h11);
        repeat (PC + 3) @(posedge clk);
        rd_expect(11'h008, 8'hFF, "R9 abort after keys");
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'h80);
        wr(11'h000, 8'hF0);
        wr(11'h555, 8'hA0);
        wr(11'h008, 8'h22);
        repeat (PC + 3) @(posedge clk);
        rd_expect(11'h008, 8'hFF, "R9 abort in erase setup");

        // R10: address from strobe start, data from strobe end
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'hA0);
        wr2(11'h009, 8'h77, 11'h00A, 8'h42);
        repeat (PC + 3) @(posedge clk);
        rd_expect(11'h009, 8'h42, "R10 captured address/data");
        rd_expect(11'h00A, 8'hFF, "R10 late address unused");
        model[9] = 8'h42;

        // R7: chip erase with exact busy window
        erase_seq();
        for (int i = 1; i <= EB + 2; i++) begin
            if (i == 1) rd_expect(11'h005, 8'h30, "R7 erase pre-start");
            else if (i <= EB + 1) rd_expect(11'h005, 8'h00, "R7 erase status");
            else rd_expect(11'h005, 8'hFF, "R7 erase done");
        end
        for (int i = 0; i < DEPTH; i++) begin
            model[i] = 8'hFF;
            rd_expect(AW'(i), 8'hFF, "R7 all erased");
        end

        // R6: commands during busy ignored
        prog_timed(3, 8'h5A, "R6 setup");
        erase_seq();
        wr(11'h555, 8'hAA);
        wr(11'h2AA, 8'h55);
        wr(11'h555, 8'hA0);
        wait_idle(11'h003, 8'hFF);
        wr(11'h003, 8'h00);
        repeat (PC + 3) @(posedge clk);
        rd_expect(11'h003, 8'hFF, "R6 writes during busy ignored");
        peek(11'h004, v);
        vcheck(v, 8'hFF, "R6 neighbour intact");

        @(posedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule